// File: doc/BRIEF.md
# Radio packet receive sequencer

This block drives a serially configured FSK receiver over a four-wire serial link made up of an active-low select, a clock, a data line towards the receiver and a data line back from it. After reset it sends a startup list of 16-bit command words: the configuration words in order, then one plain FIFO command. It then repeats the same loop for each packet. It arms the receiver FIFO and reads a fixed number of payload bytes, one checksum byte and one trailing byte that it discards. Before each byte read it waits for the receiver's active-low interrupt. It then disarms the FIFO.

The payload is kept in a small buffer and sent out on a valid/ready byte stream. After the last byte comes a single-cycle status pulse that says whether the modulo-256 sum of the payload matched the checksum byte. A toggle output changes state on every good packet.

All command words are parameters. So are the number of system clocks per serial half-period and the payload length.

Top module: `radio_rx_seq`

## Requirements
- R1: Each command frame is 16 bits, most significant bit first. Select stays low for the whole frame. The serial clock idles low, pulses only while select is low, and is low before select rises. Between frames select stays high for at least HALF_DIV system clocks.
- R2: During a command frame the returned line is sampled after each clock rising edge, 16 samples with the first one as the most significant bit. The word appears on `rsp_word` no later than the cycle in which select rises.
- R3: A FIFO byte read starts only while the interrupt input, after its two-flop synchronizer, is low. While the interrupt is held high, no read frame begins.
- R4: A FIFO byte read keeps select low and the outgoing data line low for 24 clock pulses. The returned line is sampled before each rising edge, and the received byte is the last 8 samples, first of them as the most significant bit.
- R5: After reset the block sends the N_CFG words of CFG_LIST in order, word 0 in bits [15:0] first, then IDLE_WORD.
- R6: Each packet runs in this frame order: ARM_WORD, PLEN payload reads, one checksum read, one discarded read, DISARM_WORD.
- R7: `st_good` is 1 exactly when the modulo-256 sum of the PLEN payload bytes equals the checksum byte. The discarded byte has no effect on it.
- R8: `good_toggle` inverts in the cycle of the status pulse of a good packet. On a bad packet it keeps its value.
- R9: The payload bytes leave on `pl_data` in reception order, one per `pl_valid`/`pl_ready` handshake. `pl_data` and `pl_valid` hold while `pl_ready` is low. After the last byte, `st_valid` is high for exactly one cycle.
- R10: No frame of the next packet begins until the whole payload of the current packet has been accepted.
- R11: During and right after reset: select high, clock low, `pl_valid`, `st_valid` and `good_toggle` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_int_n | input | 1 | Receiver interrupt, active low, asynchronous |
| rf_miso | input | 1 | Serial data from the receiver |
| rf_cs_n | output | 1 | Serial select, active low |
| rf_sck | output | 1 | Serial clock, idles low |
| rf_mosi | output | 1 | Serial data to the receiver |
| rsp_word | output | 16 | Response word of the last command frame |
| pl_data | output | 8 | Payload byte |
| pl_valid | output | 1 | Payload byte valid |
| pl_ready | input | 1 | Payload byte accepted by the sink |
| st_valid | output | 1 | One-cycle packet status pulse |
| st_good | output | 1 | Checksum matched (valid with st_valid) |
| good_toggle | output | 1 | Inverts on every good packet |

## Verification
A bit counter or phase error in the serial engine shows at the very next rise of select, as a frame of the wrong length, a wrong word or a clock left high. A slip in the startup or packet sequencing shows as a wrong command word in the first frame after the slip. A fault in the checksum accumulator stays hidden until the status pulse at the end of the packet, about twenty frames later, where `st_good` and `good_toggle` disagree with the bytes that were sent. A buffer or stream index fault appears on the first accepted payload byte that it touches. A handshake fault appears during a long hold of `pl_ready`, either as a change of `pl_data` or as a new frame starting before the payload has drained.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    E_IDLE,
    E_LOW,
    E_HIGH,
    E_TAIL,
    E_GAP
  } eng_st_t;

  typedef enum logic [3:0] {
    C_BOOT,
    C_BOOT_W,
    C_ARM,
    C_ARM_W,
    C_WAIT_INT,
    C_READ_W,
    C_DIS,
    C_DIS_W,
    C_FETCH,
    C_SEND,
    C_STAT
  } ctl_st_t;
endpackage

// File: rtl/rx_seq_sync.sv
module rx_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '1;
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/rx_seq_shift.sv
module rx_seq_shift
  import rx_seq_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int CMD_BITS  = 16,
  parameter int FIFO_BITS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                fifo_mode,
  input  logic [CMD_BITS-1:0] word,
  input  logic                miso,
  output logic                cs_n,
  output logic                sck,
  output logic                mosi,
  output logic                done,
  output logic [CMD_BITS-1:0] resp,
  output logic [BYTE_W-1:0]   rx_byte
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(FIFO_BITS + 1);
  localparam logic [DW-1:0] DIV_TOP = DW'(HALF_DIV - 1);

  eng_st_t            st;
  logic [DW-1:0]      div;
  logic [BW-1:0]      left;
  logic [CMD_BITS-1:0] txsh;
  logic [CMD_BITS-1:0] samp;
  logic               fifo_q;
  logic               tick;

  assign tick    = (div == '0);
  assign rx_byte = samp[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= E_IDLE;
      cs_n   <= 1'b1;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      div    <= DIV_TOP;
      left   <= '0;
      txsh   <= '0;
      samp   <= '0;
      resp   <= '0;
      fifo_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          div <= DIV_TOP;
          if (start) begin
            fifo_q <= fifo_mode;
            txsh   <= {word[CMD_BITS-2:0], 1'b0};
            left   <= fifo_mode ? BW'(FIFO_BITS) : BW'(CMD_BITS);
            cs_n   <= 1'b0;
            mosi   <= fifo_mode ? 1'b0 : word[CMD_BITS-1];
            st     <= E_LOW;
          end
        end
        E_LOW: begin
          if (tick) begin
            sck <= 1'b1;
            if (fifo_q) samp <= {samp[CMD_BITS-2:0], miso};
            div <= DIV_TOP;
            st  <= E_HIGH;
          end else begin
            div <= div - 1'b1;
          end
        end
        E_HIGH: begin
          if (tick) begin
            sck <= 1'b0;
            if (!fifo_q) samp <= {samp[CMD_BITS-2:0], miso};
            left <= left - 1'b1;
            div  <= DIV_TOP;
            if (left == BW'(1)) begin
              st <= E_TAIL;
            end else begin
              mosi <= fifo_q ? 1'b0 : txsh[CMD_BITS-1];
              txsh <= {txsh[CMD_BITS-2:0], 1'b0};
              st   <= E_LOW;
            end
          end else begin
            div <= div - 1'b1;
          end
        end
        E_TAIL: begin
          if (tick) begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            if (!fifo_q) resp <= samp;
            div  <= DIV_TOP;
            st   <= E_GAP;
          end else begin
            div <= div - 1'b1;
          end
        end
        E_GAP: begin
          if (tick) begin
            done <= 1'b1;
            st   <= E_IDLE;
          end else begin
            div <= div - 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n); // R1
  AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (!sck && !$past(sck))); // R1
  AST_GAP_HIGH: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(cs_n))); // R1
  AST_FIFO_MOSI_LOW: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && fifo_q) |-> !mosi); // R4
endmodule

// File: rtl/rx_seq_buf.sv
module rx_seq_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/rx_seq_ctrl.sv
module rx_seq_ctrl
  import rx_seq_pkg::*;
#(
  parameter int PLEN     = 16,
  parameter int CMD_BITS = 16,
  parameter int N_CFG    = 7,
  parameter logic [N_CFG*CMD_BITS-1:0] CFG_LIST = '0,
  parameter logic [CMD_BITS-1:0] IDLE_WORD   = '0,
  parameter logic [CMD_BITS-1:0] ARM_WORD    = '0,
  parameter logic [CMD_BITS-1:0] DISARM_WORD = '0,
  localparam int AW = (PLEN > 1) ? $clog2(PLEN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                int_s,
  input  logic                eng_done,
  input  logic [BYTE_W-1:0]   rx_byte,
  output logic                eng_start,
  output logic                eng_fifo,
  output logic [CMD_BITS-1:0] eng_word,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr,
  output logic                pl_valid,
  input  logic                pl_ready,
  output logic                st_valid,
  output logic                st_good,
  output logic                good_toggle
);
  localparam int N_BOOT = N_CFG + 1;
  localparam int BIW    = (N_BOOT > 1) ? $clog2(N_BOOT) : 1;
  localparam int IW     = $clog2(PLEN + 2);
  localparam logic [N_BOOT*CMD_BITS-1:0] ALL_BOOT = {IDLE_WORD, CFG_LIST};

  ctl_st_t          st;
  logic [BIW-1:0]   boot_idx;
  logic [IW-1:0]    byte_idx;
  logic [BYTE_W-1:0] sum;
  logic [BYTE_W-1:0] chk;

  assign rd_en = (st == C_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= C_BOOT;
      boot_idx    <= '0;
      byte_idx    <= '0;
      sum         <= '0;
      chk         <= '0;
      eng_start   <= 1'b0;
      eng_fifo    <= 1'b0;
      eng_word    <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      rd_addr     <= '0;
      pl_valid    <= 1'b0;
      st_valid    <= 1'b0;
      st_good     <= 1'b0;
      good_toggle <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      wr_en     <= 1'b0;
      st_valid  <= 1'b0;
      case (st)
        C_BOOT: begin
          eng_start <= 1'b1;
          eng_fifo  <= 1'b0;
          eng_word  <= ALL_BOOT[int'(boot_idx)*CMD_BITS +: CMD_BITS];
          st        <= C_BOOT_W;
        end
        C_BOOT_W: begin
          if (eng_done) begin
            if (boot_idx == BIW'(N_BOOT - 1)) begin
              st <= C_ARM;
            end else begin
              boot_idx <= boot_idx + 1'b1;
              st       <= C_BOOT;
            end
          end
        end
        C_ARM: begin
          eng_start <= 1'b1;
          eng_fifo  <= 1'b0;
          eng_word  <= ARM_WORD;
          st        <= C_ARM_W;
        end
        C_ARM_W: begin
          if (eng_done) begin
            byte_idx <= '0;
            sum      <= '0;
            st       <= C_WAIT_INT;
          end
        end
        C_WAIT_INT: begin
          if (!int_s) begin
            eng_start <= 1'b1;
            eng_fifo  <= 1'b1;
            eng_word  <= '0;
            st        <= C_READ_W;
          end
        end
        C_READ_W: begin
          if (eng_done) begin
            if (byte_idx < IW'(PLEN)) begin
              wr_en   <= 1'b1;
              wr_addr <= byte_idx[AW-1:0];
              wr_data <= rx_byte;
              sum     <= sum + rx_byte;
            end else if (byte_idx == IW'(PLEN)) begin
              chk <= rx_byte;
            end
            if (byte_idx == IW'(PLEN + 1)) begin
              st <= C_DIS;
            end else begin
              byte_idx <= byte_idx + 1'b1;
              st       <= C_WAIT_INT;
            end
          end
        end
        C_DIS: begin
          eng_start <= 1'b1;
          eng_fifo  <= 1'b0;
          eng_word  <= DISARM_WORD;
          st        <= C_DIS_W;
        end
        C_DIS_W: begin
          if (eng_done) begin
            rd_addr <= '0;
            st      <= C_FETCH;
          end
        end
        C_FETCH: begin
          pl_valid <= 1'b1;
          st       <= C_SEND;
        end
        C_SEND: begin
          if (pl_ready) begin
            pl_valid <= 1'b0;
            if (rd_addr == AW'(PLEN - 1)) begin
              st <= C_STAT;
            end else begin
              rd_addr <= rd_addr + 1'b1;
              st      <= C_FETCH;
            end
          end
        end
        C_STAT: begin
          st_valid <= 1'b1;
          st_good  <= (sum == chk);
          if (sum == chk) good_toggle <= ~good_toggle;
          st <= C_ARM;
        end
        default: st <= C_BOOT;
      endcase
    end
  end

  AST_READ_NEEDS_INT: assert property (@(posedge clk) disable iff (rst)
    (eng_start && eng_fifo) |-> !int_s); // R3
  AST_NO_FRAME_WHILE_VALID: assert property (@(posedge clk) disable iff (rst)
    pl_valid |-> !eng_start); // R10
  AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> !st_valid); // R9
  AST_TOGGLE_BAD: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_good) |-> $stable(good_toggle)); // R8
  AST_TOGGLE_GOOD: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_good) |-> (good_toggle != $past(good_toggle))); // R8
endmodule

// File: rtl/radio_rx_seq.sv
module radio_rx_seq
  import rx_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PLEN     = 16,
  parameter int N_CFG    = 7,
  parameter logic [N_CFG*16-1:0] CFG_LIST = {16'h7007, 16'h6006, 16'h5005,
                                             16'h4004, 16'h3003, 16'h2002, 16'h1001},
  parameter logic [15:0] IDLE_WORD   = 16'hE000,
  parameter logic [15:0] ARM_WORD    = 16'hE0F3,
  parameter logic [15:0] DISARM_WORD = 16'hE001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rf_int_n,
  input  logic        rf_miso,
  output logic        rf_cs_n,
  output logic        rf_sck,
  output logic        rf_mosi,
  output logic [15:0] rsp_word,
  output logic [7:0]  pl_data,
  output logic        pl_valid,
  input  logic        pl_ready,
  output logic        st_valid,
  output logic        st_good,
  output logic        good_toggle
);
  localparam int CMD_BITS = 16;
  localparam int AW = (PLEN > 1) ? $clog2(PLEN) : 1;

  logic                int_s;
  logic                eng_start, eng_fifo, eng_done;
  logic [CMD_BITS-1:0] eng_word;
  logic [BYTE_W-1:0]   rx_byte;
  logic                wr_en, rd_en;
  logic [AW-1:0]       wr_addr, rd_addr;
  logic [BYTE_W-1:0]   wr_data;

  rx_seq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(rf_int_n), .q(int_s)
  );

  rx_seq_shift #(.HALF_DIV(HALF_DIV), .CMD_BITS(CMD_BITS), .FIFO_BITS(24)) u_shift (
    .clk(clk), .rst(rst), .start(eng_start), .fifo_mode(eng_fifo),
    .word(eng_word), .miso(rf_miso), .cs_n(rf_cs_n), .sck(rf_sck),
    .mosi(rf_mosi), .done(eng_done), .resp(rsp_word), .rx_byte(rx_byte)
  );

  rx_seq_buf #(.DEPTH(PLEN), .DW(BYTE_W)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(pl_data)
  );

  rx_seq_ctrl #(
    .PLEN(PLEN), .CMD_BITS(CMD_BITS), .N_CFG(N_CFG), .CFG_LIST(CFG_LIST),
    .IDLE_WORD(IDLE_WORD), .ARM_WORD(ARM_WORD), .DISARM_WORD(DISARM_WORD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .int_s(int_s), .eng_done(eng_done), .rx_byte(rx_byte),
    .eng_start(eng_start), .eng_fifo(eng_fifo), .eng_word(eng_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .st_valid(st_valid), .st_good(st_good), .good_toggle(good_toggle)
  );

  AST_PL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data))); // R9
endmodule

// File: tb/sim_radio_rx_seq.sv
module sim_radio_rx_seq;
  localparam int B_HALF = 3;
  localparam int B_PLEN = 16;
  localparam int NPKT   = 5;
  localparam logic [7*16-1:0] B_CFG = {16'h9E27, 16'h8C16, 16'h7B05, 16'h6AF4,
                                       16'h59E3, 16'h48D2, 16'h37C1};
  localparam logic [15:0] B_IDLE = 16'hCA00;
  localparam logic [15:0] B_ARM  = 16'hCA83;
  localparam logic [15:0] B_DIS  = 16'hCA81;
  // vector: [31:24] seed, [23:16] step, [15:8] checksum offset, [0] expected good
  localparam logic [31:0] VEC [NPKT] = '{
    32'h01_03_00_01, 32'hF0_11_00_01, 32'h20_07_01_00,
    32'hFF_00_80_00, 32'h00_00_00_01 };

  logic clk = 1'b0, rst = 1'b1;
  logic rf_int_n, rf_miso = 1'b0, pl_ready = 1'b0;
  logic rf_cs_n, rf_sck, rf_mosi, pl_valid, st_valid, st_good, good_toggle;
  logic [15:0] rsp_word;
  logic [7:0]  pl_data;
  logic irq_hold = 1'b0;

  assign rf_int_n = irq_hold;
  always #2 clk = ~clk;

  radio_rx_seq #(.HALF_DIV(B_HALF), .PLEN(B_PLEN), .N_CFG(7), .CFG_LIST(B_CFG),
    .IDLE_WORD(B_IDLE), .ARM_WORD(B_ARM), .DISARM_WORD(B_DIS)) u0 (
    .clk(clk), .rst(rst), .rf_int_n(rf_int_n), .rf_miso(rf_miso),
    .rf_cs_n(rf_cs_n), .rf_sck(rf_sck), .rf_mosi(rf_mosi), .rsp_word(rsp_word),
    .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .st_valid(st_valid), .st_good(st_good), .good_toggle(good_toggle));

  int cnt_i = 0, fail_i = 0, cnt_m = 0, fail_m = 0;

  function automatic bit chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    if (!ok) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    return ok;
  endfunction

  function automatic logic [7:0] pay(int p, int i);
    logic [31:0] v = VEC[p % NPKT];
    return v[31:24] + 8'(i) * v[23:16];
  endfunction

  function automatic logic [7:0] csum(int p);
    logic [7:0] s = 8'h00;
    logic [31:0] v = VEC[p % NPKT];
    for (int i = 0; i < B_PLEN; i++) s = s + pay(p, i);
    return s + v[15:8];
  endfunction

  function automatic logic [15:0] rsp16(int idx);
    return 16'hA0C5 ^ 16'(idx * 32'h1357);
  endfunction

  // kind: 0 boot command, 1 arm, 2 read, 3 disarm
  function automatic int fkind(int idx);
    int o;
    if (idx < 8) return 0;
    o = (idx - 8) % 20;
    if (o == 0) return 1;
    if (o == 19) return 3;
    return 2;
  endfunction

  function automatic logic [23:0] fpat(int idx);
    int p, o;
    logic [7:0] b;
    if (fkind(idx) != 2) return {1'b0, rsp16(idx), 7'h00};
    p = (idx - 8) / 20;
    o = (idx - 8) % 20;
    if (o <= B_PLEN) b = pay(p, o - 1);
    else if (o == B_PLEN + 1) b = csum(p);
    else b = 8'h5A ^ 8'(p);
    return {16'hC3A5 ^ 16'(idx), b};
  endfunction

  // monitor state
  int cyc = 0, frame_idx = 0, rises = 0, last_rise = -1000;
  int pkt = 0, byte_k = 0, hold_left = 0, fall_in_hold = 0;
  int stall_left = 0, falls_stream = 0;
  bit prev_cs = 1'b1, prev_sck = 1'b0, stall_used = 1'b0, stall_bad = 1'b0;
  bit streaming = 1'b0, tog_exp = 1'b0, gexp;
  logic [23:0] pat = '0, cap = '0;
  logic [7:0]  stall_ref = '0;
  logic [15:0] expw;
  int k;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_cs = 1'b1; prev_sck = 1'b0;
    end else begin
      // sink readiness
      if (stall_left > 0) begin
        pl_ready = 1'b0;
        if (!(pl_valid && pl_data == stall_ref)) stall_bad = 1'b1;
        stall_left--;
        if (stall_left == 0) begin
          cnt_m++; if (!chk(!stall_bad, "R9 hold under stall", {31'd0, stall_bad}, 0)) fail_m++;
        end
      end else begin
        pl_ready = (cyc % 3) != 0;
      end
      if (pkt == 2 && byte_k == 0 && pl_valid && !stall_used) begin
        stall_used = 1'b1; stall_left = 400; stall_ref = pl_data; pl_ready = 1'b0;
      end
      if (pl_valid && pl_ready) begin
        cnt_m++; if (!chk(pl_data == pay(pkt, byte_k), "R9 payload byte", pl_data, pay(pkt, byte_k))) fail_m++;
        byte_k++;
      end
      // select falls: frame start
      if (prev_cs && !rf_cs_n) begin
        if (last_rise >= 0) begin
          cnt_m++; if (!chk(cyc - last_rise >= B_HALF, "R1 select gap", cyc - last_rise, B_HALF)) fail_m++;
        end
        pat = fpat(frame_idx); rises = 0; cap = '0; rf_miso = pat[23];
        if (frame_idx == 28) begin irq_hold = 1'b1; hold_left = 300; end
        else if (hold_left > 0) fall_in_hold++;
        if (streaming) falls_stream++;
      end
      if (!rf_cs_n && !prev_sck && rf_sck) begin
        cap = {cap[22:0], rf_mosi}; rises++;
        rf_miso = (rises < 24) ? pat[23 - rises] : 1'b0;
      end
      // select rises: frame end
      if (!prev_cs && rf_cs_n) begin
        k = fkind(frame_idx);
        cnt_m++; if (!chk(!rf_sck, "R1 clock low at select rise", {31'd0, rf_sck}, 0)) fail_m++;
        if (k == 2) begin
          cnt_m++; if (!chk(rises == 24 && cap == 24'h0, "R4 read frame", {rises[7:0], cap}, {8'd24, 24'h0})) fail_m++;
        end else begin
          if (k == 0) expw = (frame_idx < 7) ? B_CFG[frame_idx*16 +: 16] : B_IDLE;
          else expw = (k == 1) ? B_ARM : B_DIS;
          cnt_m++;
          if (!chk(rises == 16 && cap[15:0] == expw, (k == 0) ? "R5 boot word" : "R6 packet command",
                   {rises[15:0], cap[15:0]}, {16'd16, expw})) fail_m++;
          cnt_m++; if (!chk(rsp_word == rsp16(frame_idx), "R2 response word", rsp_word, rsp16(frame_idx))) fail_m++;
          if (k == 3) streaming = 1'b1;
        end
        frame_idx++; last_rise = cyc;
      end
      if (hold_left > 0) begin
        hold_left--;
        if (hold_left == 0) begin
          irq_hold = 1'b0;
          cnt_m++; if (!chk(fall_in_hold == 0 && frame_idx == 29, "R3 no read while interrupt high",
                            frame_idx + 1000 * fall_in_hold, 29)) fail_m++;
        end
      end
      if (st_valid) begin
        gexp = VEC[pkt % NPKT][0];
        tog_exp = tog_exp ^ gexp;
        cnt_m++; if (!chk(st_good == gexp, "R7 checksum verdict", {31'd0, st_good}, {31'd0, gexp})) fail_m++;
        cnt_m++; if (!chk(good_toggle == tog_exp, "R8 toggle", {31'd0, good_toggle}, {31'd0, tog_exp})) fail_m++;
        cnt_m++; if (!chk(byte_k == B_PLEN, "R9 bytes before status", byte_k, B_PLEN)) fail_m++;
        cnt_m++; if (!chk(falls_stream == 0, "R10 no frame during payload", falls_stream, 0)) fail_m++;
        pkt++; byte_k = 0; falls_stream = 0; streaming = 1'b0;
      end
      prev_cs = rf_cs_n; prev_sck = rf_sck;
    end
  end

  initial begin
    int wd = 0;
    bit timeout = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    cnt_i++; if (!chk(rf_cs_n && !rf_sck, "R11 serial idle in reset", {rf_cs_n, rf_sck}, 2'b10)) fail_i++;
    cnt_i++; if (!chk(!pl_valid && !st_valid && !good_toggle, "R11 outputs in reset",
                      {pl_valid, st_valid, good_toggle}, 0)) fail_i++;
    rst = 1'b0;
    @(negedge clk);
    cnt_i++; if (!chk(rf_cs_n && !pl_valid && !good_toggle, "R11 first cycle after reset",
                      {rf_cs_n, pl_valid, good_toggle}, 3'b100)) fail_i++;
    while (pkt < NPKT && !timeout) begin
      @(negedge clk);
      wd++;
      if (wd > 150000) timeout = 1'b1;
    end
    if (timeout) begin
      cnt_i++; fail_i++;
      $display("FAIL watchdog R6 packets=%0d expected=%0d", pkt, NPKT);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", cnt_i + cnt_m, fail_i + fail_m);
    $finish;
  end
endmodule